// File: doc/BRIEF.md
# Multicycle Datapath Control Sequencer

This block is the finite-state controller of a non-pipelined load/store processor. Each instruction passes through a series of steps: fetch, register read, an ALU step, an optional memory step and an optional write-back. On every clock the controller drives the datapath's multiplexor selects, the PC load and branch flags, the instruction-memory read strobe, the two-bit access codes for the register file and the data memory, and an ALU operation code. Its inputs are the 6-bit opcode field of the instruction register and the ALU zero/condition flag. The register file, memories, ALU and sign extender sit outside this block.

The number of steps depends on the instruction class. Reg-reg ALU, add-immediate and store instructions take four steps. Loads and branches take five. An opcode the controller does not recognise takes two. Every access code uses the same 2-bit encoding: 00 idle, 01 read, 10 write. The value 11 is never driven. All outputs are decoded from the current step, so each takes its new value in the same cycle the step is entered. Reset is asynchronous and active low.

Top module: `mcseq_ctrl`

## Requirements
- R1: While `rst_n` is low every output is 0. The first cycle after reset is released is a fetch step.
- R2: A fetch step drives `imem_rd`=1 and `pc_load`=1 with `is_branch`=0, both access codes 00, `alu_op`=0 and all three selects 0. It lasts one cycle.
- R3: The step after any fetch is register read: `rf_ctl`=01 and every other output 0.
- R4: Opcodes 0x00/0x01/0x02/0x03 (add/sub/and/or) take 4 steps. Step 3 drives `alu_op` 1111/1000/1001/1010 with `sel_a_pc`=0 and `sel_b_imm`=0. Step 4 drives `rf_ctl`=10 with `sel_wb_mem`=0.
- R5: Opcode 0x08 (add immediate) takes 4 steps. Step 3 drives `sel_b_imm`=1 and `alu_op`=1111. Step 4 drives `rf_ctl`=10 with `sel_wb_mem`=0.
- R6: Opcode 0x10 (load) takes 5 steps. Step 3 is an address add (`sel_b_imm`=1, `alu_op`=1111). Step 4 drives `dm_ctl`=01. Step 5 drives `rf_ctl`=10 with `sel_wb_mem`=1.
- R7: Opcode 0x11 (store) takes 4 steps. Step 3 is the same address add as for a load. Step 4 drives `dm_ctl`=10. The register file is never written.
- R8: Opcode 0x18 (branch) takes 5 steps, with `is_branch`=1 in steps 3 to 5. Step 3 computes the target (`sel_a_pc`=1, `sel_b_imm`=1, `alu_op`=1111). Step 4 compares the operands (`alu_op`=1000, selects 0). Step 5 drives `pc_load` equal to the captured condition.
- R9: `cond` is sampled only at the clock edge that ends branch step 4. Changing it at any other time has no effect on any output.
- R10: Any other opcode completes fetch and register read, then returns to fetch. No register-file or data-memory write is issued.
- R11: `opcode` is sampled only at the clock edge that ends register read. Later changes do not alter the running instruction.
- R12: Access code 11 never appears. Outside the steps named above, `rf_ctl` and `dm_ctl` are 00 and `pc_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| cond | input | 1 | ALU zero/condition flag |
| sel_a_pc | output | 1 | ALU A select: 1 = PC, 0 = register A |
| sel_b_imm | output | 1 | ALU B select: 1 = sign-extended immediate, 0 = register B |
| sel_wb_mem | output | 1 | Write-back select: 1 = loaded data, 0 = ALU result |
| is_branch | output | 1 | Branch instruction in its target/compare/update steps |
| pc_load | output | 1 | Load the PC (next sequential PC, or the target when is_branch) |
| imem_rd | output | 1 | Instruction-memory read / IR load |
| rf_ctl | output | 2 | Register-file access: 00 idle, 01 read, 10 write |
| dm_ctl | output | 2 | Data-memory access: 00 idle, 01 read, 10 write |
| alu_op | output | ALU_W | ALU code: 0 none, all ones add, 10xx others |

## Verification
Each instruction class is run back to back, so the per-class step count shows up as the spacing of fetch steps. Opcodes that share a class but differ in ALU function (add, sub, and, or) show whether the function is carried through to the compute step. Branches are run with the condition both taken and not taken, and the condition is flipped right after it is captured, which separates a captured flag from a live one. The opcode is overwritten with an unknown value once each instruction is past register read, and separate unknown opcodes check the two-step return path.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_ADD  = 6'h00;
  localparam logic [OPC_W-1:0] OPC_SUB  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_AND  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_OR   = 6'h03;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OPC_LD   = 6'h10;
  localparam logic [OPC_W-1:0] OPC_ST   = 6'h11;
  localparam logic [OPC_W-1:0] OPC_BR   = 6'h18;

  localparam logic [1:0] ACC_IDLE = 2'b00;
  localparam logic [1:0] ACC_RD   = 2'b01;
  localparam logic [1:0] ACC_WR   = 2'b10;

  typedef enum logic [2:0] {
    CL_NONE, CL_ALU, CL_ALUI, CL_LOAD, CL_STORE, CL_BRANCH
  } cls_t;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_OR} fn_t;

  typedef enum logic [2:0] {
    S_FETCH, S_REGRD, S_EXEC, S_MEM, S_WB, S_BRCHK, S_BRUPD
  } step_t;
endpackage

// File: rtl/mcseq_decode.sv
module mcseq_decode
  import mcseq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output cls_t             cls,
  output fn_t              fn
);
  always_comb begin
    cls = CL_NONE;
    fn  = FN_ADD;
    unique case (opcode)
      OPC_ADD:  cls = CL_ALU;
      OPC_SUB:  begin cls = CL_ALU; fn = FN_SUB; end
      OPC_AND:  begin cls = CL_ALU; fn = FN_AND; end
      OPC_OR:   begin cls = CL_ALU; fn = FN_OR;  end
      OPC_ADDI: cls = CL_ALUI;
      OPC_LD:   cls = CL_LOAD;
      OPC_ST:   cls = CL_STORE;
      OPC_BR:   cls = CL_BRANCH;
      default:  cls = CL_NONE;
    endcase
  end
endmodule

// File: rtl/mcseq_fsm.sv
module mcseq_fsm
  import mcseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cls_t  cls_in,
  input  fn_t   fn_in,
  input  logic  cond,
  output step_t step,
  output cls_t  cls_q,
  output fn_t   fn_q,
  output logic  cond_q
);
  step_t step_nx;

  always_comb begin
    step_nx = S_FETCH;
    unique case (step)
      S_FETCH: step_nx = S_REGRD;
      S_REGRD: step_nx = (cls_in == CL_NONE) ? S_FETCH : S_EXEC;
      S_EXEC: begin
        unique case (cls_q)
          CL_BRANCH:            step_nx = S_BRCHK;
          CL_ALU, CL_ALUI:      step_nx = S_WB;
          CL_LOAD, CL_STORE:    step_nx = S_MEM;
          default:              step_nx = S_FETCH;
        endcase
      end
      S_MEM:   step_nx = (cls_q == CL_LOAD) ? S_WB : S_FETCH;
      S_WB:    step_nx = S_FETCH;
      S_BRCHK: step_nx = S_BRUPD;
      S_BRUPD: step_nx = S_FETCH;
      default: step_nx = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= S_FETCH;
      cls_q  <= CL_NONE;
      fn_q   <= FN_ADD;
      cond_q <= 1'b0;
    end else begin
      step <= step_nx;
      if (step == S_REGRD) begin
        cls_q <= cls_in;
        fn_q  <= fn_in;
      end
      if (step == S_BRCHK) cond_q <= cond;
    end
  end
endmodule

// File: rtl/mcseq_outdec.sv
module mcseq_outdec
  import mcseq_pkg::*;
#(
  parameter int ALU_W = 4
) (
  input  logic             rst_n,
  input  step_t            step,
  input  cls_t             cls_q,
  input  fn_t              fn_q,
  input  logic             cond_q,
  output logic             sel_a_pc,
  output logic             sel_b_imm,
  output logic             sel_wb_mem,
  output logic             is_branch,
  output logic             pc_load,
  output logic             imem_rd,
  output logic [1:0]       rf_ctl,
  output logic [1:0]       dm_ctl,
  output logic [ALU_W-1:0] alu_op
);
  localparam logic [ALU_W-1:0] ALU_NOP = '0;
  localparam logic [ALU_W-1:0] ALU_ADD = '1;
  localparam logic [ALU_W-1:0] ALU_SUB = {2'b10, {(ALU_W-2){1'b0}}};
  localparam logic [ALU_W-1:0] ALU_AND = ALU_SUB | ALU_W'(1);
  localparam logic [ALU_W-1:0] ALU_OR  = ALU_SUB | ALU_W'(2);

  function automatic logic [ALU_W-1:0] fn_code(input fn_t f);
    unique case (f)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      default: return ALU_ADD;
    endcase
  endfunction

  always_comb begin
    sel_a_pc   = 1'b0;
    sel_b_imm  = 1'b0;
    sel_wb_mem = 1'b0;
    is_branch  = 1'b0;
    pc_load    = 1'b0;
    imem_rd    = 1'b0;
    rf_ctl     = ACC_IDLE;
    dm_ctl     = ACC_IDLE;
    alu_op     = ALU_NOP;
    unique case (step)
      S_FETCH: begin
        imem_rd = 1'b1;
        pc_load = 1'b1;
      end
      S_REGRD: rf_ctl = ACC_RD;
      S_EXEC: begin
        unique case (cls_q)
          CL_ALU: alu_op = fn_code(fn_q);
          CL_ALUI, CL_LOAD, CL_STORE: begin
            sel_b_imm = 1'b1;
            alu_op    = ALU_ADD;
          end
          CL_BRANCH: begin
            sel_a_pc  = 1'b1;
            sel_b_imm = 1'b1;
            alu_op    = ALU_ADD;
            is_branch = 1'b1;
          end
          default: ;
        endcase
      end
      S_MEM: dm_ctl = (cls_q == CL_LOAD) ? ACC_RD : ACC_WR;
      S_WB: begin
        rf_ctl     = ACC_WR;
        sel_wb_mem = (cls_q == CL_LOAD);
      end
      S_BRCHK: begin
        alu_op    = ALU_SUB;
        is_branch = 1'b1;
      end
      S_BRUPD: begin
        is_branch = 1'b1;
        pc_load   = cond_q;
      end
      default: ;
    endcase
    if (!rst_n) begin
      sel_a_pc   = 1'b0;
      sel_b_imm  = 1'b0;
      sel_wb_mem = 1'b0;
      is_branch  = 1'b0;
      pc_load    = 1'b0;
      imem_rd    = 1'b0;
      rf_ctl     = ACC_IDLE;
      dm_ctl     = ACC_IDLE;
      alu_op     = ALU_NOP;
    end
  end
endmodule

// File: rtl/mcseq_ctrl.sv
module mcseq_ctrl
  import mcseq_pkg::*;
#(
  parameter int ALU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       opcode,
  input  logic             cond,
  output logic             sel_a_pc,
  output logic             sel_b_imm,
  output logic             sel_wb_mem,
  output logic             is_branch,
  output logic             pc_load,
  output logic             imem_rd,
  output logic [1:0]       rf_ctl,
  output logic [1:0]       dm_ctl,
  output logic [ALU_W-1:0] alu_op
);
  cls_t  cls_dec, cls_q;
  fn_t   fn_dec, fn_q;
  step_t step;
  logic  cond_q;

  mcseq_decode u_dec (
    .opcode (opcode),
    .cls    (cls_dec),
    .fn     (fn_dec)
  );

  mcseq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cls_in (cls_dec),
    .fn_in  (fn_dec),
    .cond   (cond),
    .step   (step),
    .cls_q  (cls_q),
    .fn_q   (fn_q),
    .cond_q (cond_q)
  );

  mcseq_outdec #(.ALU_W(ALU_W)) u_out (
    .rst_n      (rst_n),
    .step       (step),
    .cls_q      (cls_q),
    .fn_q       (fn_q),
    .cond_q     (cond_q),
    .sel_a_pc   (sel_a_pc),
    .sel_b_imm  (sel_b_imm),
    .sel_wb_mem (sel_wb_mem),
    .is_branch  (is_branch),
    .pc_load    (pc_load),
    .imem_rd    (imem_rd),
    .rf_ctl     (rf_ctl),
    .dm_ctl     (dm_ctl),
    .alu_op     (alu_op)
  );
endmodule

// File: rtl/mcseq_ctrl_chk.sv
module mcseq_ctrl_chk #(
  parameter int ALU_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_a_pc,
  input logic             sel_b_imm,
  input logic             sel_wb_mem,
  input logic             is_branch,
  input logic             pc_load,
  input logic             imem_rd,
  input logic [1:0]       rf_ctl,
  input logic [1:0]       dm_ctl,
  input logic [ALU_W-1:0] alu_op
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!imem_rd && !pc_load && rf_ctl == 2'b00 &&
                                   dm_ctl == 2'b00 && alu_op == '0 && !is_branch);
    end
  end

  a_r12_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ctl != 2'b11) && (dm_ctl != 2'b11));

  a_r2_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> !imem_rd);

  a_r2_fetch_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |-> (rf_ctl == 2'b00 && dm_ctl == 2'b00 && pc_load && !is_branch));

  a_r3_read_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> (rf_ctl == 2'b01 && dm_ctl == 2'b00));

  a_r6_mem_after_address_add: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_ctl != 2'b00) |-> ($past(alu_op) == '1 && $past(sel_b_imm) && !$past(sel_a_pc)));

  a_r8_redirect_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !imem_rd) |-> (is_branch && $past(is_branch) && $past(alu_op) != '0));
endmodule

bind mcseq_ctrl mcseq_ctrl_chk #(.ALU_W(ALU_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_a_pc   (sel_a_pc),
  .sel_b_imm  (sel_b_imm),
  .sel_wb_mem (sel_wb_mem),
  .is_branch  (is_branch),
  .pc_load    (pc_load),
  .imem_rd    (imem_rd),
  .rf_ctl     (rf_ctl),
  .dm_ctl     (dm_ctl),
  .alu_op     (alu_op)
);

// File: tb/mcseq_ctrl_bench.sv
module mcseq_ctrl_bench;
  localparam int ALU_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic cond = 1'b0;
  logic sel_a_pc, sel_b_imm, sel_wb_mem, is_branch, pc_load, imem_rd;
  logic [1:0] rf_ctl, dm_ctl;
  logic [ALU_W-1:0] alu_op;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mcseq_ctrl #(.ALU_W(ALU_W)) u_mcseq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond(cond),
    .sel_a_pc(sel_a_pc), .sel_b_imm(sel_b_imm), .sel_wb_mem(sel_wb_mem),
    .is_branch(is_branch), .pc_load(pc_load), .imem_rd(imem_rd),
    .rf_ctl(rf_ctl), .dm_ctl(dm_ctl), .alu_op(alu_op)
  );

  wire [13:0] obs = {sel_a_pc, sel_b_imm, sel_wb_mem, is_branch, pc_load,
                     imem_rd, rf_ctl, dm_ctl, alu_op};

  function automatic logic [13:0] ev(input logic a, b, w, br, pc, im,
                                     input logic [1:0] rf, dm,
                                     input logic [3:0] alu);
    return {a, b, w, br, pc, im, rf, dm, alu};
  endfunction

  task automatic push(input logic [13:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // monitor: pops one expected step per cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [13:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (obs !== e) begin
        failures++;
        $display("FAIL %s: actual=%b expected=%b", t, obs, e);
      end
    end
  end

  // driver: one instruction, expected steps queued, inputs held per step
  task automatic do_instr(input logic [5:0] opc, input logic cv);
    int n;
    logic [3:0] c;
    push(ev(0,0,0,0,1,1,2'b00,2'b00,4'h0), "R2 fetch");
    push(ev(0,0,0,0,0,0,2'b01,2'b00,4'h0), "R3 register read");
    n = 4;
    case (opc)
      6'h00, 6'h01, 6'h02, 6'h03: begin
        c = (opc == 6'h00) ? 4'hF : (opc == 6'h01) ? 4'h8 :
            (opc == 6'h02) ? 4'h9 : 4'hA;
        push(ev(0,0,0,0,0,0,2'b00,2'b00,c), "R4 alu compute");
        push(ev(0,0,0,0,0,0,2'b10,2'b00,4'h0), "R4 alu write");
      end
      6'h08: begin
        push(ev(0,1,0,0,0,0,2'b00,2'b00,4'hF), "R5 addi compute");
        push(ev(0,0,0,0,0,0,2'b10,2'b00,4'h0), "R5 addi write");
      end
      6'h10: begin
        n = 5;
        push(ev(0,1,0,0,0,0,2'b00,2'b00,4'hF), "R6 load address");
        push(ev(0,0,0,0,0,0,2'b00,2'b01,4'h0), "R6 load memory read");
        push(ev(0,0,1,0,0,0,2'b10,2'b00,4'h0), "R6 load write");
      end
      6'h11: begin
        push(ev(0,1,0,0,0,0,2'b00,2'b00,4'hF), "R7 store address");
        push(ev(0,0,0,0,0,0,2'b00,2'b10,4'h0), "R7 store memory write");
      end
      6'h18: begin
        n = 5;
        push(ev(1,1,0,1,0,0,2'b00,2'b00,4'hF), "R8 branch target");
        push(ev(0,0,0,1,0,0,2'b00,2'b00,4'h8), "R8 branch compare");
        push(ev(0,0,0,1,cv,0,2'b00,2'b00,4'h0), "R9 branch update");
      end
      default: n = 2;
    endcase
    opcode = opc;
    cond = cv;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      #1;
      if (i == 2) opcode = 6'h3F;   // R11: late opcode change
      if (i == 4) cond = ~cv;       // R9: flip after capture
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (obs !== 14'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual=%b expected=%b", obs, 14'b0);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;                   // R1: fetch follows release
    do_instr(6'h00, 1'b1);
    do_instr(6'h01, 1'b0);
    do_instr(6'h02, 1'b1);
    do_instr(6'h03, 1'b0);
    do_instr(6'h08, 1'b1);
    do_instr(6'h10, 1'b0);
    do_instr(6'h11, 1'b1);
    do_instr(6'h18, 1'b1);
    do_instr(6'h18, 1'b0);
    do_instr(6'h05, 1'b1);          // R10 unknown opcode
    do_instr(6'h3F, 1'b0);          // R10 unknown opcode
    do_instr(6'h10, 1'b1);
    do_instr(6'h18, 1'b1);
    push(ev(0,0,0,0,1,1,2'b00,2'b00,4'h0), "R10 R12 return to fetch");
    @(posedge clk);
    #1;
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule